// File: doc/BRIEF.md
# Trimmed Temperature Code Converter

The block converts in either direction between a temperature in whole degrees Celsius and the 8-bit code that an on-chip thermal sensor reports. The conversion applies the chip's calibration, which is given as two sensor codes: one measured at 25 °C (`calLo`) and one measured at 85 °C (`calHi`). A run-time mode picks one of three calibrations. With no trimming the code is the temperature plus 50. With one-point trimming the code is the temperature shifted by `calLo - 25`. With two-point trimming the code also follows the slope between the two calibration points, and that slope correction needs a division.

A conversion starts with a one-cycle `start` pulse. The inputs must be valid in that cycle. The operands are loaded into a serial restoring divider. Every mode and direction runs through that divider, so the latency is the same in all cases. The result is saturated to 0..255. It appears together with a one-cycle `done` strobe and stays on the outputs until the next strobe. If two-point mode is requested with equal calibration codes, the block uses one-point behaviour and flags the error.

Top module: `temp_code_conv`

## Requirements
- R1: With `trimMode` = 0 and `toTemp` = 0, the result is valIn + 50.
- R2: With `trimMode` = 0 and `toTemp` = 1, the result is valIn - 50.
- R3: With `trimMode` = 1, the forward result is valIn + calLo - 25 and the inverse result is valIn - calLo + 25.
- R4: With `trimMode` = 2 and `toTemp` = 0, the result is (valIn - 25) * (calHi - calLo) / 60 + calLo. The quotient is truncated toward zero.
- R5: With `trimMode` = 2 and `toTemp` = 1, the result is (valIn - calLo) * 60 / (calHi - calLo) + 25. The quotient is truncated toward zero.
- R6: Every result is clamped to the range 0 to 255.
- R7: `trimMode` = 3 behaves exactly like `trimMode` = 0.
- R8: With `trimMode` = 2 and calHi equal to calLo, the one-point equation is used and `calErr` is 1 alongside `done`. In all other cases `calErr` is 0 alongside `done`.
- R9: `done` is high for exactly one cycle, 17 clock edges after the edge that accepts `start`. `busy` is high from the accepting edge until `done` rises, and `busy` is low while `done` is high.
- R10: A `start` that arrives while `busy` is high is ignored. It produces no extra `done`, and the result of the conversion in flight is not changed.
- R11: `result` and `calErr` change only at the edge that raises `done`, and they hold their values between strobes.
- R12: After reset, `result`, `done`, `calErr` and `busy` are all 0.
- R13: A `start` given in the cycle where `done` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request that begins a conversion |
| toTemp | input | 1 | 0: temperature to code, 1: code to temperature |
| trimMode | input | 2 | 0 none, 1 one-point, 2 two-point, 3 treated as none |
| valIn | input | 8 | Temperature in °C or sensor code to convert |
| calLo | input | 8 | Calibration code measured at 25 °C |
| calHi | input | 8 | Calibration code measured at 85 °C |
| result | output | 8 | Converted and saturated value |
| done | output | 1 | One-cycle strobe that marks a new result |
| calErr | output | 1 | Two-point mode was requested with equal calibration codes |
| busy | output | 1 | A conversion is in progress |

## Verification
A new request can be accepted in the same cycle that shows the previous `done` strobe. The bench provokes this by chaining conversions, raising `start` at the very sample point where `done` is seen. It then judges each result's value and the exact cycle of its strobe against a queue of expected entries. The bench also checks the opposite case: a `start` given mid-conversion must leave the queue without an extra strobe and must leave the result in flight intact.

// File: rtl/temp_conv_pkg.sv
package temp_conv_pkg;

  typedef enum logic [1:0] {
    TRIM_NONE = 2'd0,
    TRIM_ONE  = 2'd1,
    TRIM_TWO  = 2'd2,
    TRIM_RSVD = 2'd3
  } trimMode_e;

  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } ctlStrobe_t;

endpackage

// File: rtl/temp_conv_ctrl.sv
module temp_conv_ctrl
  import temp_conv_pkg::*;
#(
  parameter int NUM_W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output ctlStrobe_t strb,
  output logic       busy
);
  localparam int CNT_W = $clog2(NUM_W);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_e;

  state_e            state;
  logic [CNT_W-1:0]  stepCnt;

  always_comb begin
    strb = '0;
    case (state)
      S_IDLE:  strb.load   = start;
      S_RUN:   strb.step   = 1'b1;
      S_FIN:   strb.finish = 1'b1;
      default: strb        = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stepCnt <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state   <= S_RUN;
          stepCnt <= '0;
        end
        S_RUN: begin
          if (stepCnt == CNT_W'(NUM_W - 1)) state <= S_FIN;
          stepCnt <= stepCnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/temp_conv_datapath.sv
module temp_conv_datapath
  import temp_conv_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int REF_LO   = 25,
  parameter int REF_HI   = 85,
  parameter int NONE_OFS = 50
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic              toTemp,
  input  logic [1:0]        trimMode,
  input  logic [CODE_W-1:0] valIn,
  input  logic [CODE_W-1:0] calLo,
  input  logic [CODE_W-1:0] calHi,
  output logic [CODE_W-1:0] result,
  output logic              done,
  output logic              calErr
);
  localparam int NUM_W = 2 * CODE_W;
  localparam int SW    = CODE_W + 2;
  localparam int PW    = 2 * SW;
  localparam logic signed [PW-1:0] P_LO   = PW'(REF_LO);
  localparam logic signed [PW-1:0] P_SPAN = PW'(REF_HI - REF_LO);
  localparam logic signed [PW-1:0] P_NOFS = PW'(NONE_OFS);
  localparam logic signed [PW-1:0] P_MAX  = PW'((1 << CODE_W) - 1);

  // operand set-up
  logic signed [PW-1:0] vP, loP, hiP, numS, denS, ofsS;
  logic                 degen;
  trimMode_e            effMode;

  always_comb begin
    vP    = signed'({{(PW-CODE_W){1'b0}}, valIn});
    loP   = signed'({{(PW-CODE_W){1'b0}}, calLo});
    hiP   = signed'({{(PW-CODE_W){1'b0}}, calHi});
    degen = (trimMode == TRIM_TWO) && (calLo == calHi);
    if (trimMode == TRIM_TWO && !degen)        effMode = TRIM_TWO;
    else if (trimMode == TRIM_ONE || degen)    effMode = TRIM_ONE;
    else                                       effMode = TRIM_NONE;
    numS = vP;
    denS = PW'(1);
    ofsS = toTemp ? -P_NOFS : P_NOFS;
    case (effMode)
      TRIM_ONE: ofsS = toTemp ? (P_LO - loP) : (loP - P_LO);
      TRIM_TWO: begin
        if (toTemp) begin
          numS = (vP - loP) * P_SPAN;
          denS = hiP - loP;
          ofsS = P_LO;
        end else begin
          numS = (vP - P_LO) * (hiP - loP);
          denS = P_SPAN;
          ofsS = loP;
        end
      end
      default: ;
    endcase
  end

  logic signed [PW-1:0] numAbs, denAbs;
  assign numAbs = numS[PW-1] ? -numS : numS;
  assign denAbs = denS[PW-1] ? -denS : denS;

  // serial restoring divider state
  logic [NUM_W-1:0]     quo;
  logic [CODE_W-1:0]    rem, divR;
  logic                 negR, errPend;
  logic signed [PW-1:0] ofsR;
  logic [CODE_W:0]      shifted;
  logic                 fits;

  assign shifted = {rem, quo[NUM_W-1]};
  assign fits    = (shifted >= {1'b0, divR});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      quo     <= '0;
      rem     <= '0;
      divR    <= '0;
      negR    <= 1'b0;
      ofsR    <= '0;
      errPend <= 1'b0;
    end else if (strb.load) begin
      quo     <= NUM_W'(numAbs);
      rem     <= '0;
      divR    <= CODE_W'(denAbs);
      negR    <= numS[PW-1] ^ denS[PW-1];
      ofsR    <= ofsS;
      errPend <= degen;
    end else if (strb.step) begin
      rem <= fits ? CODE_W'(shifted - {1'b0, divR}) : shifted[CODE_W-1:0];
      quo <= {quo[NUM_W-2:0], fits};
    end
  end

  // signed recombination and saturation
  logic signed [PW-1:0] qS, sumS;
  logic [CODE_W-1:0]    clamped;

  always_comb begin
    qS   = signed'({{(PW-NUM_W){1'b0}}, quo});
    sumS = (negR ? -qS : qS) + ofsR;
    if (sumS < 0)          clamped = '0;
    else if (sumS > P_MAX) clamped = '1;
    else                   clamped = sumS[CODE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result <= '0;
      done   <= 1'b0;
      calErr <= 1'b0;
    end else begin
      done <= strb.finish;
      if (strb.finish) begin
        result <= clamped;
        calErr <= errPend;
      end
    end
  end

endmodule

// File: rtl/temp_code_conv.sv
module temp_code_conv
  import temp_conv_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int REF_LO   = 25,
  parameter int REF_HI   = 85,
  parameter int NONE_OFS = 50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              toTemp,
  input  logic [1:0]        trimMode,
  input  logic [CODE_W-1:0] valIn,
  input  logic [CODE_W-1:0] calLo,
  input  logic [CODE_W-1:0] calHi,
  output logic [CODE_W-1:0] result,
  output logic              done,
  output logic              calErr,
  output logic              busy
);
  localparam int NUM_W = 2 * CODE_W;

  ctlStrobe_t strb;

  temp_conv_ctrl #(.NUM_W(NUM_W)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .strb  (strb),
    .busy  (busy)
  );

  temp_conv_datapath #(
    .CODE_W   (CODE_W),
    .REF_LO   (REF_LO),
    .REF_HI   (REF_HI),
    .NONE_OFS (NONE_OFS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .toTemp   (toTemp),
    .trimMode (trimMode),
    .valIn    (valIn),
    .calLo    (calLo),
    .calHi    (calHi),
    .result   (result),
    .done     (done),
    .calErr   (calErr)
  );

endmodule

// File: rtl/temp_code_conv_chk.sv
module temp_code_conv_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [1:0]        trimMode,
  input logic [CODE_W-1:0] calLo,
  input logic [CODE_W-1:0] calHi,
  input logic [CODE_W-1:0] result,
  input logic              done,
  input logic              calErr,
  input logic              busy
);
  localparam int LAT   = 2 * CODE_W + 1;
  localparam int CNT_W = $clog2(LAT + 2) + 1;

  logic             armed, errLat;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed  <= 1'b0;
      cnt    <= '0;
      errLat <= 1'b0;
    end else if (start && !busy) begin
      armed  <= 1'b1;
      cnt    <= '0;
      errLat <= (trimMode == 2'd2) && (calLo == calHi);
    end else begin
      if (done) armed <= 1'b0;
      else if (armed) cnt <= cnt + 1'b1;
    end
  end

  // R9: strobe lands a fixed count after acceptance
  a_r9_latency: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (armed && cnt == CNT_W'(LAT)));

  a_r9_single_done: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r9_idle_on_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  a_r8_err_flag: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (calErr == errLat));

  a_r11_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(result) |-> done);

  a_r11_err_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(calErr) |-> done);

endmodule

bind temp_code_conv temp_code_conv_chk #(.CODE_W(CODE_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .trimMode (trimMode),
  .calLo    (calLo),
  .calHi    (calHi),
  .result   (result),
  .done     (done),
  .calErr   (calErr),
  .busy     (busy)
);

// File: tb/sim_temp_code_conv.sv
`timescale 1ns/1ps
module sim_temp_code_conv;
  logic       clk = 1'b0;
  logic       rstN, start, toTemp, calErr, done, busy;
  logic [1:0] trimMode;
  logic [7:0] valIn, calLo, calHi, result;

  always #5 clk = ~clk;

  temp_code_conv u0 (
    .clk(clk), .rstN(rstN), .start(start), .toTemp(toTemp),
    .trimMode(trimMode), .valIn(valIn), .calLo(calLo), .calHi(calHi),
    .result(result), .done(done), .calErr(calErr), .busy(busy)
  );

  typedef struct {
    int    res;
    bit    err;
    int    expCyc;
    string tag;
  } item_t;

  item_t q[$];
  int    nChecks = 0, nFails = 0, cyc = 0;
  int    lastRes = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int modelConv(bit dir, int mode, int v, int lo, int hi,
                                   output bit err);
    int r;
    err = 0;
    if (mode == 2 && lo == hi) begin mode = 1; err = 1; end
    if (mode == 3) mode = 0;
    case (mode)
      0:       r = dir ? v - 50 : v + 50;
      1:       r = dir ? v - lo + 25 : v + lo - 25;
      default: r = dir ? (v - lo) * 60 / (hi - lo) + 25
                       : (v - 25) * (hi - lo) / 60 + lo;
    endcase
    if (r < 0) r = 0;
    if (r > 255) r = 255;
    return r;
  endfunction

  task automatic check(bit ok, string tag, int act, int expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // driver: called at a negedge; pushes the expected item and pulses start
  task automatic issue(bit dir, int mode, int v, int lo, int hi, string tag);
    item_t it;
    bit    e;
    it.res    = modelConv(dir, mode, v, lo, hi, e);
    it.err    = e;
    it.expCyc = cyc + 18;
    it.tag    = tag;
    q.push_back(it);
    toTemp = dir; trimMode = 2'(mode); valIn = 8'(v); calLo = 8'(lo); calHi = 8'(hi);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone();
    do @(negedge clk); while (!done);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && done) begin
      if (q.size() == 0) begin
        check(0, "R10 unexpected done", 1, 0);
      end else begin
        item_t it;
        it = q.pop_front();
        check(result == 8'(it.res), it.tag, result, it.res);
        check(calErr == it.err, {it.tag, " R8 calErr"}, calErr, it.err);
        check(cyc == it.expCyc, {it.tag, " R9 latency"}, cyc, it.expCyc);
        check(!busy, "R9 busy low at done", busy, 0);
        lastRes = result;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "watchdog", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; start = 1'b0; toTemp = 1'b0; trimMode = 2'd0;
    valIn = '0; calLo = '0; calHi = '0;
    repeat (3) @(negedge clk);
    check(result == 0, "R12 result", result, 0);
    check(done == 0,   "R12 done", done, 0);
    check(calErr == 0, "R12 calErr", calErr, 0);
    check(busy == 0,   "R12 busy", busy, 0);
    rstN = 1'b1;
    @(negedge clk);

    // chained conversions: each next start lands in the done cycle (R13)
    issue(0, 0, 30, 0, 0, "R1 none fwd");        waitDone();
    issue(1, 0, 80, 0, 0, "R2 none inv");        waitDone();
    issue(0, 1, 40, 60, 0, "R3 one fwd");        waitDone();
    issue(1, 1, 90, 60, 0, "R3 one inv R13");    waitDone();
    issue(0, 2, 30, 50, 110, "R4 two fwd");      waitDone();
    issue(0, 2, 31, 46, 120, "R4 two fwd trunc"); waitDone();
    issue(0, 2, 10, 46, 120, "R4 two fwd neg");  waitDone();
    issue(1, 2, 53, 46, 120, "R5 two inv");      waitDone();
    issue(1, 2, 30, 46, 120, "R5 two inv neg");  waitDone();
    issue(0, 0, 240, 0, 0, "R6 sat high");       waitDone();
    issue(1, 0, 20, 0, 0, "R6 sat low");         waitDone();
    issue(0, 2, 200, 120, 46, "R6 sat slope");   waitDone();
    issue(0, 3, 77, 9, 9, "R7 reserved fwd");    waitDone();
    issue(1, 3, 77, 9, 9, "R7 reserved inv");    waitDone();
    issue(0, 2, 70, 90, 90, "R8 degenerate");    waitDone();
    issue(1, 2, 70, 90, 91, "R8 clean");         waitDone();

    // R10: a start while busy is ignored
    @(negedge clk);
    issue(0, 1, 100, 30, 0, "R10 in flight");
    repeat (5) @(negedge clk);
    toTemp = 1'b1; trimMode = 2'd0; valIn = 8'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone();
    repeat (25) @(negedge clk);
    check(q.size() == 0, "R10 no extra done", q.size(), 0);

    // R11: outputs hold while inputs move and no conversion runs
    valIn = 8'd200; calLo = 8'd3; trimMode = 2'd2;
    repeat (6) @(negedge clk);
    check(result == 8'(lastRes), "R11 result holds", result, lastRes);
    check(done == 0, "R11 no done", done, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule